// File: doc/BRIEF.md
# Polled SPI Codec Write Controller

This block is a single 32-bit host register that drives a write-only SPI transmitter for one codec. The host writes a 16-bit payload into the low half of the word, together with an enable bit and a start bit. The block then sends the payload out on a serial clock, a data line and an active-low chip select. The start bit doubles as a busy flag. It reads as 1 for as long as the transfer runs and drops by itself when the last bit has gone out, so software only has to poll the register.

The bits above the enable bit carry no function. They hold whatever the host last wrote and return it on every read. The serial clock idles low. Data changes on the falling edge and is valid on the rising edge. Each half period of the serial clock lasts a parameter number of system clocks, so a transfer takes a small, fixed number of cycles, far inside any millisecond-scale polling timeout.

Top module: `spi_ctl_top`

## Requirements
- R1: After reset the register reads 0x00000000, `spi_cs_n` is 1 and `spi_sclk` is 0.
- R2: A write accepted while idle, with bit 17 (enable) = 1 and bit 16 (start) = 1, launches a transfer. Bit 16 reads 1 from the cycle after the write.
- R3: During a transfer, bits 15:0 of the written word go out on `spi_mosi` MSB first. Exactly 16 rising edges of `spi_sclk` occur, and each rising edge finds the next bit stable.
- R4: Each half period of `spi_sclk` is HALF_DIV system clocks. `spi_sclk` stays low while `spi_cs_n` is high. `spi_cs_n` is low for exactly 32*HALF_DIV system clocks per transfer.
- R5: Bit 16 returns to 0 by itself on the same clock edge at which `spi_cs_n` returns high.
- R6: Bits 31:18, bit 17 and bits 15:0 read back as last accepted and are kept unchanged through a transfer.
- R7: A write with bit 16 = 1 and bit 17 = 0 is stored (bit 16 reads 0), and no transfer starts: `spi_cs_n` stays high.
- R8: A write with bit 16 = 0 and bit 17 = 1 is stored, and the transmitter stays idle with `spi_cs_n` high.
- R9: A write that arrives while a transfer runs, and before its final cycle, is ignored entirely: the register contents and the bits being sent are unchanged.
- R10: A write that arrives in the final cycle of a transfer, the one whose edge ends it, is accepted as if the block were idle. If that write launches, the new payload follows with `spi_cs_n` held low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_data | input | 32 | Host write word |
| rd_data | output | 32 | Register contents; bit 16 is the busy flag |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data, MSB first |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Two events can fall in the same cycle: a host write and the completion of a running transfer. At that edge the busy flag is still set, yet the write has to be taken. The bench times a launching write to land exactly 32*HALF_DIV cycles after the previous launch. It checks that the busy flag never drops, that chip select stays low, and that the serial stream carries both payloads back to back. A second write placed one cycle earlier must instead leave the register and the stream untouched.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
   // Whether the transmitter is currently moving a word.
   typedef enum logic {
      XMIT_IDLE  = 1'b0,
      XMIT_SHIFT = 1'b1
   } xmit_state_e;

   // Number of system clocks a full transfer takes.
   function automatic int xfer_cycles(input int pay_w, input int half_div);
      return 2 * pay_w * half_div;
   endfunction
endpackage

// File: rtl/spi_ctl_tick.sv
module spi_ctl_tick #(
   parameter int HALF_DIV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   output logic tick
);
   localparam int TW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_ctl_tick: HALF_DIV must be at least 1");
      end

      if (HALF_DIV == 1) begin : g_every_cycle
         assign tick = run;
      end else begin : g_divided
         localparam logic [TW-1:0] LAST = TW'(HALF_DIV - 1);
         logic [TW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart || !run) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == LAST);

         AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST); // R4
      end
   endgenerate
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift
   import spi_ctl_pkg::*;
#(
   parameter int PAY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [PAY_W-1:0] payload,
   input  logic             tick,
   output logic             active,
   output logic             done,
   output logic             sclk,
   output logic             mosi,
   output logic             cs_n
);
   localparam int CNT_W = (PAY_W > 1) ? $clog2(PAY_W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(PAY_W - 1);

   generate
      if (PAY_W < 2) begin : g_bad_width
         $error("spi_ctl_shift: PAY_W must be at least 2");
      end
   endgenerate

   xmit_state_e      state_q;
   logic [PAY_W-1:0] shreg_q;
   logic [CNT_W-1:0] bitcnt_q;
   logic             sclk_q;
   logic             cs_n_q;
   logic             last_bit;

   assign last_bit = (bitcnt_q == LAST_BIT);
   assign active   = (state_q == XMIT_SHIFT);
   assign done     = active && tick && sclk_q && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= XMIT_IDLE;
         shreg_q  <= '0;
         bitcnt_q <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
      end else if (start) begin
         state_q  <= XMIT_SHIFT;
         shreg_q  <= payload;
         bitcnt_q <= '0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b0;
      end else if (active && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
         end else begin
            sclk_q  <= 1'b0;
            shreg_q <= {shreg_q[PAY_W-2:0], 1'b0};
            if (last_bit) begin
               state_q <= XMIT_IDLE;
               cs_n_q  <= 1'b1;
            end else begin
               bitcnt_q <= bitcnt_q + 1'b1;
            end
         end
      end
   end

   assign sclk = sclk_q;
   assign cs_n = cs_n_q;
   assign mosi = shreg_q[PAY_W-1];

   AST_SCLK_LOW_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q); // R4
   AST_DATA_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && $rose(sclk_q)) |-> $stable(shreg_q)); // R3
   AST_DONE_RAISES_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> cs_n_q); // R5
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs #(
   parameter int DATA_W = 32,
   parameter int PAY_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              done,
   output logic              launch,
   output logic [PAY_W-1:0]  payload,
   output logic              busy,
   output logic [DATA_W-1:0] rd_data
);
   localparam int GO_POS = PAY_W;
   localparam int EN_POS = PAY_W + 1;
   localparam logic [DATA_W-1:0] GO_MASK = DATA_W'(1) << GO_POS;

   generate
      if (DATA_W < PAY_W + 2) begin : g_bad_width
         $error("spi_ctl_regs: DATA_W too narrow for payload plus control bits");
      end
   endgenerate

   logic [DATA_W-1:0] store_q;
   logic              busy_q;
   logic              accept;

   // The completion cycle frees the register for the write presented in it.
   assign accept  = wr_en && (!busy_q || done);
   assign launch  = accept && wr_data[GO_POS] && wr_data[EN_POS];
   assign payload = wr_data[PAY_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store_q <= '0;
         busy_q  <= 1'b0;
      end else begin
         if (accept) begin
            store_q <= wr_data & ~GO_MASK;
         end
         if (launch) begin
            busy_q <= 1'b1;
         end else if (done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy    = busy_q;
   assign rd_data = store_q | (busy_q ? GO_MASK : '0);

   AST_BUSY_BLOCKS_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> $stable(store_q)); // R9
   AST_NO_LAUNCH_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_q && !wr_data[EN_POS]) |=> !busy_q); // R7
   AST_IDLE_WRITE_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !busy_q && !wr_data[GO_POS]) |=> !busy_q); // R8
   AST_STORAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(store_q)); // R6
endmodule

// File: rtl/spi_ctl_top.sv
module spi_ctl_top #(
   parameter int DATA_W   = 32,
   parameter int PAY_W    = 16,
   parameter int HALF_DIV = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              spi_sclk,
   output logic              spi_mosi,
   output logic              spi_cs_n
);
   localparam int GO_POS = PAY_W;

   logic             launch;
   logic             done;
   logic             busy;
   logic             active;
   logic             tick;
   logic [PAY_W-1:0] payload;

   spi_ctl_regs #(.DATA_W(DATA_W), .PAY_W(PAY_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .done    (done),
      .launch  (launch),
      .payload (payload),
      .busy    (busy),
      .rd_data (rd_data)
   );

   spi_ctl_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (active),
      .restart (launch),
      .tick    (tick)
   );

   spi_ctl_shift #(.PAY_W(PAY_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (launch),
      .payload (payload),
      .tick    (tick),
      .active  (active),
      .done    (done),
      .sclk    (spi_sclk),
      .mosi    (spi_mosi),
      .cs_n    (spi_cs_n)
   );

   AST_BUSY_TRACKS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !spi_cs_n); // R5
   AST_LAUNCH_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> rd_data[GO_POS]); // R2
endmodule

// File: tb/spi_ctl_top_bench.sv
module spi_ctl_top_bench;
   localparam int H     = 2;
   localparam int XFER  = 2 * 16 * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        spi_sclk, spi_mosi, spi_cs_n;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          ncap  = 0;
   int          cslow = 0;
   logic [63:0] cap   = '0;

   always #4 clk = ~clk;

   spi_ctl_top #(.DATA_W(32), .PAY_W(16), .HALF_DIV(H)) u_spi_ctl_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_cs_n(spi_cs_n)
   );

   always @(posedge spi_sclk) begin
      cap  = {cap[62:0], spi_mosi};
      ncap = ncap + 1;
   end

   always @(negedge clk) if (rst_n && !spi_cs_n) cslow = cslow + 1;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      cap = '0; ncap = 0; cslow = 0;
   endtask

   task automatic host_wr(input logic [31:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (rd_data[16] && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   function automatic logic [31:0] mk(input logic [13:0] up, input logic en,
                                      input logic go, input logic [15:0] p);
      return {up, en, go, p};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      int n;
      logic [15:0] p, p2;
      logic [13:0] up;
      logic [31:0] w;

      repeat (3) @(negedge clk);
      chk("R1 rd", rd_data, 0);
      chk("R1 cs_n", spi_cs_n, 1);
      chk("R1 sclk", spi_sclk, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep: walking ones plus fixed patterns, with varied upper bits
      for (int i = 0; i < 22; i++) begin
         case (i)
            16: p = 16'h0000;
            17: p = 16'hFFFF;
            18: p = 16'hA5C3;
            19: p = 16'h3C5A;
            20: p = 16'h8001;
            21: p = 16'h7FFE;
            default: p = 16'h0001 << i;
         endcase
         up = 14'(i * 16'h2A5 + 3);

         clear_mon();
         w = mk(up, 1'b1, 1'b0, p);
         host_wr(w);                     // R8 enable only
         repeat (4) @(negedge clk);
         chk("R8 cs_n idle", spi_cs_n, 1);
         chk("R8 stored", rd_data, w);
         chk("R8 no clocks", ncap, 0);

         w = mk(up, 1'b1, 1'b1, p);
         host_wr(w);
         chk("R2 busy bit", rd_data[16], 1);
         chk("R2 cs_n low", spi_cs_n, 0);
         wait_idle(n);
         chk("R5 busy clears after 32*H", n, XFER);
         chk("R3 bit count", ncap, 16);
         chk("R3 msb-first data", cap[15:0], p);
         chk("R4 cs low span", cslow, XFER);
         chk("R4 sclk idle", spi_sclk, 0);
         chk("R6 readback", rd_data, mk(up, 1'b1, 1'b0, p));
      end

      // R7: start without enable is stored but idle
      clear_mon();
      w = mk(14'h1234, 1'b0, 1'b1, 16'hBEEF);
      host_wr(w);
      repeat (6) @(negedge clk);
      chk("R7 go reads 0", rd_data, mk(14'h1234, 1'b0, 1'b0, 16'hBEEF));
      chk("R7 cs_n high", spi_cs_n, 1);
      chk("R7 no clocks", ncap, 0);

      // R9: write mid-transfer ignored
      clear_mon();
      p = 16'hC0DE; p2 = 16'h1111;
      host_wr(mk(14'h0AAA, 1'b1, 1'b1, p));
      repeat (5) @(negedge clk);
      host_wr(mk(14'h3555, 1'b1, 1'b1, p2));
      chk("R9 register unchanged", rd_data, mk(14'h0AAA, 1'b1, 1'b1, p));
      wait_idle(n);
      chk("R9 stream unchanged", cap[15:0], p);
      chk("R9 count", ncap, 16);
      chk("R9 after", rd_data, mk(14'h0AAA, 1'b1, 1'b0, p));

      // R9: write one cycle before completion ignored
      clear_mon();
      p = 16'h5A5A;
      host_wr(mk(14'h0F0F, 1'b1, 1'b1, p));
      repeat (XFER - 2) @(negedge clk);
      host_wr(mk(14'h00FF, 1'b1, 1'b1, 16'h9999));
      chk("R9 late busy", rd_data, mk(14'h0F0F, 1'b1, 1'b1, p));
      @(negedge clk);
      chk("R9 late done", rd_data, mk(14'h0F0F, 1'b1, 1'b0, p));
      chk("R9 late cs_n", spi_cs_n, 1);
      chk("R9 late count", ncap, 16);

      // R10: write in completion cycle accepted, back to back
      clear_mon();
      p = 16'hDEAD; p2 = 16'h4B1D;
      host_wr(mk(14'h2222, 1'b1, 1'b1, p));
      repeat (XFER - 1) @(negedge clk);
      host_wr(mk(14'h1357, 1'b1, 1'b1, p2));
      chk("R10 still busy", rd_data, mk(14'h1357, 1'b1, 1'b1, p2));
      chk("R10 cs held", spi_cs_n, 0);
      wait_idle(n);
      chk("R10 second span", n, XFER);
      chk("R10 stream", cap[31:0], {p, p2});
      chk("R10 count", ncap, 32);
      chk("R10 cs low span", cslow, 2 * XFER);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule